// File: doc/BRIEF.md
# Transmit Descriptor and Status Ring Sequencer

This block keeps the books for a transmit DMA engine whose work list lives in two memory rings. One ring holds descriptors of two words each: a buffer address, then a control word. The other holds one-word completion records. Software builds descriptors and then tells the block how many new ones are ready by pulsing an enqueue input with a count. The block walks the descriptor ring in order. It fetches each descriptor through a single-word read port and hands the buffer address, length, index and end-of-frame marker to the frame-send interface. When the send path returns a result, the block writes a packed completion word into the status ring and raises a sticky transmit interrupt.

Each ring has its own base address, start address and byte length, and each wraps to its base when the next address reaches base plus length. Work begins only while both the transmit enable and the transmit DMA enable are high and at least one descriptor is outstanding. A descriptor marked for abort is never offered to the send path. It completes at once with an aborted status.

Top module: `txq_top`

## Requirements
- R1: While reset is held, no read, write or send request is raised, `irq` is low and `pending` is 0.
- R2: An enqueue pulse adds `enq_count` to `pending`, and each accepted status write (wr_req with wr_ack) takes one away. Both apply in the same cycle when they coincide.
- R3: A descriptor fetch starts only if `pending` is nonzero and both `tx_enable` and `dma_tx_enable` are high.
- R4: A descriptor is read as two words: the buffer address at the current descriptor address, then the control word at that address plus 4. The control word carries end of frame in bit 31, buffer index in bits 30:16, abort in bit 15 and length in bits 11:0. Bits 14:12 are ignored. The fields are offered on the send interface and held stable until `snd_ready`.
- R5: A descriptor whose abort bit (bit 15) is set is not offered for sending. Its status word has bit 31 set, bit 29 set, bit 30 clear, every result field clear, and its index in bits 14:0.
- R6: A status word for a sent frame has processed in bit 31, no-error in bit 30, carrier loss in bit 28, late collision in bit 26, underrun in bit 25, excessive collisions in bit 24, collision count in bits 20:16 and the echoed buffer index in bits 14:0. Bits 29, 27, 23:21 and 15 are zero.
- R7: Status words are written at the current status address, which then advances by 4 and returns to the status base when it reaches base plus byte length.
- R8: After each completed frame the descriptor address advances by 8 and returns to the descriptor base when it reaches base plus byte length.
- R9: Every status write sets a sticky interrupt flag. `irq` is that flag ANDed with `irq_enable`. `irq_clear` clears the flag, but a status write in the same cycle wins.
- R10: Frames complete strictly in ring order, one at a time, and at most one of read request, send request and status write request is active at any moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable | input | 1 | Transmitter enable |
| dma_tx_enable | input | 1 | Transmit DMA enable |
| ring_load | input | 1 | Loads both current addresses from their start inputs |
| desc_base | input | 32 | Descriptor ring base byte address |
| desc_start | input | 32 | Descriptor current address loaded by ring_load |
| desc_bytes | input | 16 | Descriptor ring length in bytes |
| stat_base | input | 32 | Status ring base byte address |
| stat_start | input | 32 | Status current address loaded by ring_load |
| stat_bytes | input | 16 | Status ring length in bytes |
| enq_valid | input | 1 | Enqueue pulse |
| enq_count | input | 8 | Descriptors added by the enqueue pulse |
| mem_rd_req | output | 1 | Word read request, held until mem_rd_valid |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rd_valid | input | 1 | Read data valid, completes the request |
| mem_rd_data | input | 32 | Read data |
| mem_wr_req | output | 1 | Status word write request, held until mem_wr_ack |
| mem_wr_addr | output | 32 | Status write byte address |
| mem_wr_data | output | 32 | Packed status word |
| mem_wr_ack | input | 1 | Write accepted |
| snd_valid | output | 1 | Frame send request |
| snd_ready | input | 1 | Send path accepts the request |
| snd_buf_addr | output | 32 | Frame buffer address |
| snd_len | output | 12 | Frame length in bytes |
| snd_idx | output | 15 | Buffer index |
| snd_last | output | 1 | End-of-frame marker from the descriptor |
| res_valid | input | 1 | Send result valid |
| res_ok | input | 1 | Frame sent without error |
| res_no_carrier | input | 1 | Carrier lost during send |
| res_late_coll | input | 1 | Collision outside the window |
| res_underrun | input | 1 | Transmit underrun |
| res_excess_coll | input | 1 | Too many collisions |
| res_coll_cnt | input | 5 | Collision count |
| irq_enable | input | 1 | Transmit interrupt enable |
| irq_clear | input | 1 | Clears the sticky interrupt flag |
| irq | output | 1 | Transmit interrupt |
| pending | output | 16 | Outstanding descriptor count |

## Verification
A wrong ring pointer shows up at the memory port on the next fetch or status write. It appears as an address that misses the expected slot, most visibly on the first pass after a wrap. A wrong pending count shows within one cycle on `pending`, and later as a fetch that starts with nothing enqueued or as work that stalls. A wrong status packing or abort decision appears in the status word written for that same frame, and a stuck or lost interrupt flag is visible on `irq` in the cycle after the write.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam int DESC_STEP = 8;
    localparam int STAT_STEP = 4;
    localparam int WORD_BYTES = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ADDR,
        ST_RD_CTRL,
        ST_SEND,
        ST_WAIT_RES,
        ST_WR_STAT
    } txq_state_e;

    typedef struct packed {
        logic        last;
        logic [14:0] idx;
        logic        abort;
        logic [11:0] len;
    } txq_ctrl_t;

    typedef struct packed {
        logic       ok;
        logic       no_carrier;
        logic       late_coll;
        logic       underrun;
        logic       excess_coll;
        logic [4:0] coll_cnt;
    } txq_result_t;

    function automatic txq_ctrl_t txq_unpack_ctrl(input logic [31:0] w);
        txq_ctrl_t c;
        c.last  = w[31];
        c.idx   = w[30:16];
        c.abort = w[15];
        c.len   = w[11:0];
        return c;
    endfunction

endpackage

// File: rtl/txq_ring_ptr.sv
module txq_ring_ptr #(
    parameter int AW   = 32,
    parameter int LW   = 16,
    parameter int STEP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] bytes,
    input  logic          adv,
    output logic [AW-1:0] cur
);
    localparam logic [AW-1:0] STEP_A = AW'(STEP);

    logic [AW-1:0] cur_d, cur_q;
    logic [AW-1:0] limit;
    logic [AW-1:0] incr;

    always_comb begin
        limit = base + AW'(bytes);
        incr  = cur_q + STEP_A;
        cur_d = cur_q;
        if (load) begin
            cur_d = load_addr;
        end else if (adv) begin
            cur_d = (incr >= limit) ? base : incr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign cur = cur_q;
endmodule

// File: rtl/txq_pend_cnt.sv
module txq_pend_cnt #(
    parameter int CW = 16,
    parameter int EW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_valid,
    input  logic [EW-1:0] inc_count,
    input  logic          dec,
    output logic [CW-1:0] count
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] add_v;
    logic [CW-1:0] sub_v;

    always_comb begin
        add_v = inc_valid ? CW'(inc_count) : '0;
        sub_v = dec ? CW'(1) : '0;
        cnt_d = cnt_q + add_v - sub_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/txq_stat_pack.sv
module txq_stat_pack
    import txq_pkg::*;
(
    input  logic        aborted,
    input  txq_result_t res,
    input  logic [14:0] idx,
    output logic [31:0] word
);
    txq_result_t eff;

    always_comb begin
        eff  = aborted ? '0 : res;
        word = '0;
        word[31]    = 1'b1;
        word[30]    = eff.ok;
        word[29]    = aborted;
        word[28]    = eff.no_carrier;
        word[26]    = eff.late_coll;
        word[25]    = eff.underrun;
        word[24]    = eff.excess_coll;
        word[20:16] = eff.coll_cnt;
        word[14:0]  = idx;
    end
endmodule

// File: rtl/txq_top.sv
module txq_top
    import txq_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int EW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_enable,
    input  logic          dma_tx_enable,
    input  logic          ring_load,
    input  logic [AW-1:0] desc_base,
    input  logic [AW-1:0] desc_start,
    input  logic [LW-1:0] desc_bytes,
    input  logic [AW-1:0] stat_base,
    input  logic [AW-1:0] stat_start,
    input  logic [LW-1:0] stat_bytes,
    input  logic          enq_valid,
    input  logic [EW-1:0] enq_count,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_valid,
    input  logic [31:0]   mem_rd_data,
    output logic          mem_wr_req,
    output logic [AW-1:0] mem_wr_addr,
    output logic [31:0]   mem_wr_data,
    input  logic          mem_wr_ack,
    output logic          snd_valid,
    input  logic          snd_ready,
    output logic [31:0]   snd_buf_addr,
    output logic [11:0]   snd_len,
    output logic [14:0]   snd_idx,
    output logic          snd_last,
    input  logic          res_valid,
    input  logic          res_ok,
    input  logic          res_no_carrier,
    input  logic          res_late_coll,
    input  logic          res_underrun,
    input  logic          res_excess_coll,
    input  logic [4:0]    res_coll_cnt,
    input  logic          irq_enable,
    input  logic          irq_clear,
    output logic          irq,
    output logic [CW-1:0] pending
);
    localparam logic [AW-1:0] CTRL_OFS = AW'(WORD_BYTES);

    typedef struct packed {
        txq_state_e  state;
        logic [31:0] buf_addr;
        txq_ctrl_t   ctrl;
        logic [31:0] stat_word;
        logic        irq_flag;
    } regs_t;

    regs_t r_d, r_q;

    logic [AW-1:0] desc_cur;
    logic [AW-1:0] stat_cur;
    logic          frame_done;
    logic          start_ok;
    txq_result_t   res_in;
    txq_ctrl_t     rd_ctrl;
    logic          pk_abort;
    logic [14:0]   pk_idx;
    logic [31:0]   pk_word;

    // Both rings step once per completed frame.
    txq_ring_ptr #(.AW(AW), .LW(LW), .STEP(DESC_STEP)) desc_ptr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ring_load),
        .load_addr (desc_start),
        .base      (desc_base),
        .bytes     (desc_bytes),
        .adv       (frame_done),
        .cur       (desc_cur)
    );

    txq_ring_ptr #(.AW(AW), .LW(LW), .STEP(STAT_STEP)) stat_ptr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ring_load),
        .load_addr (stat_start),
        .base      (stat_base),
        .bytes     (stat_bytes),
        .adv       (frame_done),
        .cur       (stat_cur)
    );

    txq_pend_cnt #(.CW(CW), .EW(EW)) pend_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_valid (enq_valid),
        .inc_count (enq_count),
        .dec       (frame_done),
        .count     (pending)
    );

    always_comb begin
        res_in.ok          = res_ok;
        res_in.no_carrier  = res_no_carrier;
        res_in.late_coll   = res_late_coll;
        res_in.underrun    = res_underrun;
        res_in.excess_coll = res_excess_coll;
        res_in.coll_cnt    = res_coll_cnt;
        rd_ctrl            = txq_unpack_ctrl(mem_rd_data);
        pk_abort           = (r_q.state == ST_RD_CTRL);
        pk_idx             = pk_abort ? rd_ctrl.idx : r_q.ctrl.idx;
    end

    txq_stat_pack pack_i (
        .aborted (pk_abort),
        .res     (res_in),
        .idx     (pk_idx),
        .word    (pk_word)
    );

    always_comb begin
        start_ok   = (pending != '0) && tx_enable && dma_tx_enable;
        frame_done = (r_q.state == ST_WR_STAT) && mem_wr_ack;
        r_d        = r_q;

        case (r_q.state)
            ST_IDLE: begin
                if (start_ok) begin
                    r_d.state = ST_RD_ADDR;
                end
            end
            ST_RD_ADDR: begin
                if (mem_rd_valid) begin
                    r_d.buf_addr = mem_rd_data;
                    r_d.state    = ST_RD_CTRL;
                end
            end
            ST_RD_CTRL: begin
                if (mem_rd_valid) begin
                    r_d.ctrl = rd_ctrl;
                    if (rd_ctrl.abort) begin
                        r_d.stat_word = pk_word;
                        r_d.state     = ST_WR_STAT;
                    end else begin
                        r_d.state = ST_SEND;
                    end
                end
            end
            ST_SEND: begin
                if (snd_ready) begin
                    r_d.state = ST_WAIT_RES;
                end
            end
            ST_WAIT_RES: begin
                if (res_valid) begin
                    r_d.stat_word = pk_word;
                    r_d.state     = ST_WR_STAT;
                end
            end
            ST_WR_STAT: begin
                if (mem_wr_ack) begin
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (frame_done) begin
            r_d.irq_flag = 1'b1;
        end else if (irq_clear) begin
            r_d.irq_flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, buf_addr: '0, ctrl: '0, stat_word: '0, irq_flag: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mem_rd_req   = (r_q.state == ST_RD_ADDR) || (r_q.state == ST_RD_CTRL);
        mem_rd_addr  = (r_q.state == ST_RD_CTRL) ? (desc_cur + CTRL_OFS) : desc_cur;
        mem_wr_req   = (r_q.state == ST_WR_STAT);
        mem_wr_addr  = stat_cur;
        mem_wr_data  = r_q.stat_word;
        snd_valid    = (r_q.state == ST_SEND);
        snd_buf_addr = r_q.buf_addr;
        snd_len      = r_q.ctrl.len;
        snd_idx      = r_q.ctrl.idx;
        snd_last     = r_q.ctrl.last;
        irq          = r_q.irq_flag && irq_enable;
    end
endmodule

// File: rtl/txq_chk.sv
module txq_chk #(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int EW = 8,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_enable,
    input logic          dma_tx_enable,
    input logic [AW-1:0] stat_base,
    input logic [LW-1:0] stat_bytes,
    input logic          enq_valid,
    input logic [EW-1:0] enq_count,
    input logic          mem_rd_req,
    input logic          mem_wr_req,
    input logic [AW-1:0] mem_wr_addr,
    input logic [31:0]   mem_wr_data,
    input logic          mem_wr_ack,
    input logic          snd_valid,
    input logic          snd_ready,
    input logic [31:0]   snd_buf_addr,
    input logic [11:0]   snd_len,
    input logic [14:0]   snd_idx,
    input logic          irq_enable,
    input logic          irq,
    input logic [CW-1:0] pending
);
    // R10
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_req, snd_valid, mem_wr_req}));

    // R4
    snd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snd_valid && !snd_ready |=> snd_valid && $stable(snd_buf_addr)
                                    && $stable(snd_len) && $stable(snd_idx));

    // R3
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_req) |-> $past(pending) != '0 && $past(tx_enable) && $past(dma_tx_enable));

    // R2
    pend_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req && mem_wr_ack |=>
            pending == $past(pending) - CW'(1) + ($past(enq_valid) ? CW'($past(enq_count)) : '0));

    // R6
    stat_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> mem_wr_data[31] && !mem_wr_data[27] && !mem_wr_data[15]);

    // R5
    abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req && mem_wr_data[29] |-> !mem_wr_data[30] && mem_wr_data[20:16] == 5'd0);

    // R7
    stat_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> mem_wr_addr >= stat_base && mem_wr_addr < stat_base + AW'(stat_bytes));

    // R9
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req && mem_wr_ack |=> irq || !irq_enable);
endmodule

bind txq_top txq_chk #(.AW(AW), .LW(LW), .EW(EW), .CW(CW)) chk_i (.*);

// File: tb/txq_top_tb_top.sv
module txq_top_tb_top;
    typedef struct packed {
        logic        abort;
        logic [11:0] len;
        logic [14:0] idx;
        logic        ok;
        logic        car;
        logic        late;
        logic        und;
        logic        exc;
        logic [4:0]  coll;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b0, 12'd64,   15'd0,      1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0},
        '{1'b1, 12'd100,  15'd1,      1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 5'd7},
        '{1'b0, 12'd1514, 15'd2,      1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd3},
        '{1'b0, 12'd4095, 15'd3,      1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd31},
        '{1'b0, 12'd60,   15'h7fff,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd16},
        '{1'b0, 12'd1,    15'd5,      1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1},
        '{1'b1, 12'd200,  15'd6,      1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 5'd2},
        '{1'b0, 12'd2044, 15'h4321,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0}
    };
    localparam logic [31:0] DBASE = 32'h0000_1000;
    localparam logic [31:0] SBASE = 32'h0000_2000;

    logic clk = 1'b0;
    logic rst_n, tx_enable, dma_tx_enable, ring_load;
    logic [31:0] desc_base, desc_start, stat_base, stat_start;
    logic [15:0] desc_bytes, stat_bytes;
    logic enq_valid;
    logic [7:0] enq_count;
    logic mem_rd_req, mem_rd_valid, mem_wr_req, mem_wr_ack;
    logic [31:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;
    logic snd_valid, snd_ready, snd_last;
    logic [31:0] snd_buf_addr;
    logic [11:0] snd_len;
    logic [14:0] snd_idx;
    logic res_valid, res_ok, res_no_carrier, res_late_coll, res_underrun, res_excess_coll;
    logic [4:0] res_coll_cnt;
    logic irq_enable, irq_clear, irq;
    logic [15:0] pending;

    always #4 clk = ~clk;

    txq_top dut_i (.*);

    logic [31:0] dmem [0:7];
    logic [31:0] rd_cap [0:2*NV-1];
    logic [31:0] wa_cap [0:NV-1];
    logic [31:0] wd_cap [0:NV-1];
    logic [31:0] sa_cap [0:NV-1];
    logic [11:0] sl_cap [0:NV-1];
    logic [14:0] si_cap [0:NV-1];
    logic        se_cap [0:NV-1];
    int rd_cnt = 0, wr_cnt = 0, sd_cnt = 0;
    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;
    bit need_res = 1'b0;
    int res_dly = 0, snd_hold = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_word(input vec_t v);
        return {1'b1, v.idx, v.abort, 3'b101, v.len};
    endfunction

    function automatic logic [31:0] exp_stat(input vec_t v);
        logic [31:0] w = 32'h8000_0000;
        w[14:0] = v.idx;
        if (v.abort) w[29] = 1'b1;
        else begin
            w[30] = v.ok; w[28] = v.car; w[26] = v.late;
            w[25] = v.und; w[24] = v.exc; w[20:16] = v.coll;
        end
        return w;
    endfunction

    task automatic load_slots(input int first);
        for (int s = 0; s < 4; s++) begin
            dmem[2*s]   = 32'h8000_0000 + 32'((first + s) * 32'h800);
            dmem[2*s+1] = ctrl_word(VEC[first + s]);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    // Memory, send path and result responders, all on the falling edge.
    initial begin
        mem_rd_valid = 0; mem_rd_data = '0; mem_wr_ack = 0; snd_ready = 0;
        res_valid = 0; res_ok = 0; res_no_carrier = 0; res_late_coll = 0;
        res_underrun = 0; res_excess_coll = 0; res_coll_cnt = '0;
        forever begin
            @(negedge clk);
            if (res_valid) res_valid = 0;
            else if (need_res) begin
                if (res_dly == 0) begin
                    res_ok = VEC[wr_cnt].ok; res_no_carrier = VEC[wr_cnt].car;
                    res_late_coll = VEC[wr_cnt].late; res_underrun = VEC[wr_cnt].und;
                    res_excess_coll = VEC[wr_cnt].exc; res_coll_cnt = VEC[wr_cnt].coll;
                    res_valid = 1; need_res = 0;
                end else res_dly--;
            end
            if (snd_ready) begin
                snd_ready = 0; snd_hold = sd_cnt % 3;
            end else if (snd_valid) begin
                if (snd_hold == 0) begin
                    if (sd_cnt < NV) begin
                        sa_cap[sd_cnt] = snd_buf_addr; sl_cap[sd_cnt] = snd_len;
                        si_cap[sd_cnt] = snd_idx; se_cap[sd_cnt] = snd_last;
                    end
                    sd_cnt++;
                    snd_ready = 1; need_res = 1; res_dly = sd_cnt % 2;
                end else snd_hold--;
            end
            if (mem_rd_valid) mem_rd_valid = 0;
            else if (mem_rd_req) begin
                if (rd_cnt < 2*NV) rd_cap[rd_cnt] = mem_rd_addr;
                rd_cnt++;
                mem_rd_data = dmem[(mem_rd_addr - DBASE) >> 2 & 32'd7];
                mem_rd_valid = 1;
            end
            if (mem_wr_ack) mem_wr_ack = 0;
            else if (mem_wr_req) begin
                if (wr_cnt < NV) begin
                    wa_cap[wr_cnt] = mem_wr_addr; wd_cap[wr_cnt] = mem_wr_data;
                end
                wr_cnt++;
                mem_wr_ack = 1;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog act=%h exp=%h", wr_cnt, NV);
            summary();
        end
    end

    initial begin
        rst_n = 0; tx_enable = 0; dma_tx_enable = 0; ring_load = 0;
        desc_base = DBASE; desc_start = DBASE; desc_bytes = 16'd32;
        stat_base = SBASE; stat_start = SBASE; stat_bytes = 16'd16;
        enq_valid = 0; enq_count = '0; irq_enable = 0; irq_clear = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(mem_rd_req == 0, "R1 rd_req", 32'(mem_rd_req), 0);
        chk(mem_wr_req == 0, "R1 wr_req", 32'(mem_wr_req), 0);
        chk(snd_valid == 0, "R1 snd_valid", 32'(snd_valid), 0);
        chk(irq == 0, "R1 irq", 32'(irq), 0);
        chk(pending == 0, "R1 pending", 32'(pending), 0);
        rst_n = 1; ring_load = 1;
        @(negedge clk);
        ring_load = 0;
        load_slots(0);
        enq_valid = 1; enq_count = 8'd4;
        @(negedge clk);
        enq_valid = 0; enq_count = '0;
        chk(pending == 16'd4, "R2 enqueue count", 32'(pending), 4);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(mem_rd_req == 0, "R3 no fetch while disabled", 32'(mem_rd_req), 0);
            tx_enable = (i == 2);
        end
        chk(mem_rd_req == 0, "R3 no fetch with dma off", 32'(mem_rd_req), 0);
        tx_enable = 1; dma_tx_enable = 1;
        while (wr_cnt < 4) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(pending == 0, "R2 drained", 32'(pending), 0);
        chk(irq == 0, "R9 masked irq", 32'(irq), 0);
        irq_enable = 1;
        @(negedge clk);
        chk(irq == 1, "R9 sticky flag", 32'(irq), 1);
        irq_clear = 1;
        @(negedge clk);
        irq_clear = 0;
        chk(irq == 0, "R9 clear", 32'(irq), 0);
        load_slots(4);
        for (int i = 0; i < 4; i++) begin
            enq_valid = 1; enq_count = 8'd1;
            @(negedge clk);
        end
        enq_valid = 0; enq_count = '0;
        while (wr_cnt < NV) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(irq == 1, "R9 raised again", 32'(irq), 1);
        chk(pending == 0, "R2 single enqueues drained", 32'(pending), 0);
        chk(sd_cnt == 6, "R5 aborted frames not sent", 32'(sd_cnt), 6);
        begin
            int j = 0;
            for (int k = 0; k < NV; k++) begin
                chk(rd_cap[2*k] == DBASE + 32'((k % 4) * 8), "R8 descriptor address wrap",
                    rd_cap[2*k], DBASE + 32'((k % 4) * 8));
                chk(rd_cap[2*k+1] == DBASE + 32'((k % 4) * 8 + 4), "R4 control word address",
                    rd_cap[2*k+1], DBASE + 32'((k % 4) * 8 + 4));
                chk(wa_cap[k] == SBASE + 32'((k % 4) * 4), "R7 status address wrap",
                    wa_cap[k], SBASE + 32'((k % 4) * 4));
                chk(wd_cap[k] == exp_stat(VEC[k]), VEC[k].abort ? "R5 abort status" : "R6 status word",
                    wd_cap[k], exp_stat(VEC[k]));
                if (!VEC[k].abort && j < NV) begin
                    chk(sa_cap[j] == 32'h8000_0000 + 32'(k * 32'h800), "R10 in-order buffer address",
                        sa_cap[j], 32'h8000_0000 + 32'(k * 32'h800));
                    chk(sl_cap[j] == VEC[k].len, "R4 length", 32'(sl_cap[j]), 32'(VEC[k].len));
                    chk(si_cap[j] == VEC[k].idx, "R4 index", 32'(si_cap[j]), 32'(VEC[k].idx));
                    chk(se_cap[j] == 1'b1, "R4 end of frame", 32'(se_cap[j]), 1);
                    j++;
                end
            end
        end
        done = 1;
        summary();
    end
endmodule